// File: doc/BRIEF.md
# Trapezoidal Shaper Phase Sequencer

This block produces the digital controls for a switched-capacitor, time-variant shaping filter that sits behind a charge preamplifier in a pixel readout channel. Each frame is cut into four sub-intervals of equal length, `SUB_CYC` clock cycles each. The first sub-interval integrates the preamplifier baseline into a feedback capacitor. The capacitor is then reversed, its orientation swapped while the input is disconnected. The third sub-interval integrates the signal, so the filter output carries the difference between signal and baseline, which is a correlated double sample. In the fourth sub-interval a converter strobe fires and the shaper is cleared.

Frames start in one of two ways. In triggered bursts, a trigger launches a programmed number of back-to-back frames. In continuous operation, frames repeat for as long as the run enable stays high. When run is lowered, the frame in progress always finishes, and the block then parks with every switch open. All outputs are registered.

Top module: `shp_seq_top`

## Requirements
- R1: While reset is asserted, and afterwards as long as no frame has been started, `sw_ctl`, `pre_rst`, `smp_stb` and `shp_rst` are all 0.
- R2: Let cycle c of a frame have sub-interval s = c / SUB_CYC and offset o = c % SUB_CYC. Then `sw_ctl[0]` (input switch) is 1 when s is 0 or 2 and o ≠ 0. `sw_ctl[1]` and `sw_ctl[4]` (baseline orientation pair) are 1 when s = 0 and o ≠ 0. `sw_ctl[2]` and `sw_ctl[3]` (reversed orientation pair) are 1 when s = 1 and o ≠ 0, and for the whole of s = 2 and s = 3.
- R3: The baseline pair and the reversed pair are never closed in the same cycle. At offset 0 of sub-intervals 0 and 1, all four capacitor switches are open.
- R4: `pre_rst` is 1 for exactly one cycle, the first cycle of each frame, and all switches are open in that cycle.
- R5: `smp_stb` is 1 only at s = 3, o = 1. `shp_rst` is 1 only at s = 3, o = SUB_CYC-1. Each is one cycle wide.
- R6: Baseline integration (input switch and baseline pair both closed) and signal integration (input switch and reversed pair both closed) each last SUB_CYC-1 cycles per frame.
- R7: When idle, with `run`=1 and `cont_mode`=0, a trigger sampled at a clock edge starts `n_frames` back-to-back frames. The first cycle of the first frame follows that edge directly. Triggers during a burst are ignored. `n_frames` = 0 starts nothing.
- R8: With `run`=1 and `cont_mode`=1, frames start without a trigger and follow one another with no gap.
- R9: When `run` falls mid-frame, that frame completes unchanged and the outputs then stay 0. While `run`=0, triggers start nothing.
- R10: A frame is exactly 4*SUB_CYC cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables frame starts; when low, parks after the current frame |
| cont_mode | input | 1 | 1: continuous frames, 0: triggered bursts |
| trig | input | 1 | Burst start request, sampled at the clock edge |
| n_frames | input | FRAME_W | Number of frames per burst |
| sw_ctl | output | 5 | Switch enables: bit0 input, bits 1/4 baseline pair, bits 2/3 reversed pair |
| pre_rst | output | 1 | Preamplifier reset pulse |
| smp_stb | output | 1 | Converter sample strobe |
| shp_rst | output | 1 | Shaper clear pulse |

## Verification
Every cycle of each frame is compared against a per-cycle pattern model, so a wrong phase, a wrong offset or a missing dead cycle shows up at the exact cycle where it occurs. The stimulus covers:
- bursts of one and three frames, which separate the per-frame count from the back-to-back chaining;
- a trigger pulsed mid-burst, which shows that retriggering cannot extend a burst;
- a zero frame count, which must start nothing;
- continuous running with run dropped halfway through a frame, which tells a clean finish apart from an abrupt stop;
- triggers applied while run is low, which must have no effect.

Integration lengths are counted from the switch outputs, which confirms that the baseline and signal windows are equal.

// File: rtl/shp_seq_pkg.sv
package shp_seq_pkg;

    localparam int NUM_SW = 5;

    typedef struct packed {
        logic [NUM_SW-1:0] sw;
        logic              pre;
        logic              smp;
        logic              shr;
    } seq_out_t;

endpackage

// File: rtl/shp_seq_timer.sv
module shp_seq_timer #(
    parameter int SUB_CYC = 10,
    localparam int OFF_W = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_d,
    output logic [1:0]       sub_d,
    output logic [OFF_W-1:0] off_d,
    output logic             last_q
);

    localparam logic [OFF_W-1:0] OFF_END = OFF_W'(SUB_CYC - 1);

    typedef struct packed {
        logic             running;
        logic [1:0]       sub;
        logic [OFF_W-1:0] off;
    } tmr_t;

    tmr_t st_q, st_d;

    assign last_q = st_q.running && (st_q.sub == 2'd3) && (st_q.off == OFF_END);

    always_comb begin
        st_d         = st_q;
        st_d.running = act_d;
        if (!act_d || !st_q.running || last_q) begin
            st_d.sub = 2'd0;
            st_d.off = '0;
        end else if (st_q.off == OFF_END) begin
            st_d.sub = st_q.sub + 2'd1;
            st_d.off = '0;
        end else begin
            st_d.off = st_q.off + OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sub_d = st_d.sub;
    assign off_d = st_d.off;

endmodule

// File: rtl/shp_seq_decode.sv
module shp_seq_decode
    import shp_seq_pkg::*;
#(
    parameter int SUB_CYC = 10,
    localparam int OFF_W = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1
) (
    input  logic             act,
    input  logic [1:0]       sub,
    input  logic [OFF_W-1:0] off,
    output seq_out_t         pat
);

    localparam logic [OFF_W-1:0] OFF_END = OFF_W'(SUB_CYC - 1);
    localparam logic [OFF_W-1:0] OFF_STB = OFF_W'(1);

    logic first, in_base, in_flip, in_sig, in_out;

    always_comb begin
        first   = (off == '0);
        in_base = act && (sub == 2'd0);
        in_flip = act && (sub == 2'd1);
        in_sig  = act && (sub == 2'd2);
        in_out  = act && (sub == 2'd3);

        pat       = '0;
        pat.pre   = in_base && first;
        pat.sw[0] = (in_base || in_sig) && !first;
        pat.sw[1] = in_base && !first;
        pat.sw[4] = in_base && !first;
        pat.sw[2] = (in_flip && !first) || in_sig || in_out;
        pat.sw[3] = (in_flip && !first) || in_sig || in_out;
        pat.smp   = in_out && (off == OFF_STB);
        pat.shr   = in_out && (off == OFF_END);
    end

endmodule

// File: rtl/shp_seq_ctrl.sv
module shp_seq_ctrl #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               cont_mode,
    input  logic               trig,
    input  logic [FRAME_W-1:0] n_frames,
    input  logic               last_q,
    output logic               act_d
);

    typedef struct packed {
        logic               active;
        logic               cont;
        logic [FRAME_W-1:0] left;
    } ctl_t;

    ctl_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (run && (cont_mode || (trig && (n_frames != '0)))) begin
                st_d.active = 1'b1;
                st_d.cont   = cont_mode;
                st_d.left   = n_frames;
            end
        end else if (last_q) begin
            if (run && (st_q.cont || (st_q.left > FRAME_W'(1)))) begin
                if (!st_q.cont) st_d.left = st_q.left - FRAME_W'(1);
            end else begin
                st_d.active = 1'b0;
                st_d.left   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_d = st_d.active;

endmodule

// File: rtl/shp_seq_top.sv
module shp_seq_top
    import shp_seq_pkg::*;
#(
    parameter int SUB_CYC = 10,
    parameter int FRAME_W = 8,
    localparam int OFF_W = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               cont_mode,
    input  logic               trig,
    input  logic [FRAME_W-1:0] n_frames,
    output logic [4:0]         sw_ctl,
    output logic               pre_rst,
    output logic               smp_stb,
    output logic               shp_rst
);

    logic             act_d;
    logic             last_q;
    logic [1:0]       sub_d;
    logic [OFF_W-1:0] off_d;
    seq_out_t         pat_d, out_q;

    initial begin
        if (SUB_CYC < 3) $error("SUB_CYC must be at least 3");
    end

    shp_seq_ctrl #(.FRAME_W(FRAME_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cont_mode (cont_mode),
        .trig      (trig),
        .n_frames  (n_frames),
        .last_q    (last_q),
        .act_d     (act_d)
    );

    shp_seq_timer #(.SUB_CYC(SUB_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_d  (act_d),
        .sub_d  (sub_d),
        .off_d  (off_d),
        .last_q (last_q)
    );

    shp_seq_decode #(.SUB_CYC(SUB_CYC)) u_dec (
        .act (act_d),
        .sub (sub_d),
        .off (off_d),
        .pat (pat_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= pat_d;
    end

    assign sw_ctl  = out_q.sw;
    assign pre_rst = out_q.pre;
    assign smp_stb = out_q.smp;
    assign shp_rst = out_q.shr;

endmodule

// File: rtl/shp_seq_chk.sv
module shp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] sw_ctl,
    input logic       pre_rst,
    input logic       smp_stb,
    input logic       shp_rst
);

    p_pairs_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !((sw_ctl[1] || sw_ctl[4]) && (sw_ctl[2] || sw_ctl[3])));

    p_flip_dead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ctl[2]) |-> !$past(sw_ctl[1]) && !$past(sw_ctl[4]));

    p_pre_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_rst |-> (sw_ctl == 5'b0));

    p_pre_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_rst |=> !pre_rst);

    p_stb_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb && !shp_rst);

    p_shr_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shp_rst |-> !smp_stb && !pre_rst);

    p_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shp_rst |=> pre_rst || (sw_ctl == 5'b0));

endmodule

bind shp_seq_top shp_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_ctl  (sw_ctl),
    .pre_rst (pre_rst),
    .smp_stb (smp_stb),
    .shp_rst (shp_rst)
);

// File: tb/tb_shp_seq_top.sv
module tb_shp_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int SUB = 10;
    localparam int FW  = 8;
    localparam int FRAME = 4 * SUB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          cont_mode = 1'b0;
    logic          trig = 1'b0;
    logic [FW-1:0] n_frames = '0;
    logic [4:0]    sw_ctl;
    logic          pre_rst, smp_stb, shp_rst;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shp_seq_top #(.SUB_CYC(SUB), .FRAME_W(FW)) dut (
        .clk (clk), .rst_n (rst_n), .run (run), .cont_mode (cont_mode),
        .trig (trig), .n_frames (n_frames), .sw_ctl (sw_ctl),
        .pre_rst (pre_rst), .smp_stb (smp_stb), .shp_rst (shp_rst)
    );

    function automatic logic [7:0] expect_at(input int c);
        int s, o;
        logic [7:0] v;
        s = c / SUB;
        o = c % SUB;
        v = '0;
        v[0] = (s == 0 || s == 2) && o != 0;
        v[1] = (s == 0) && o != 0;
        v[4] = v[1];
        v[2] = (s == 1 && o != 0) || s == 2 || s == 3;
        v[3] = v[2];
        v[5] = (s == 0) && o == 0;
        v[6] = (s == 3) && o == 1;
        v[7] = (s == 3) && o == SUB - 1;
        return v;
    endfunction

    function automatic logic [7:0] observed();
        return {shp_rst, smp_stb, pre_rst, sw_ctl};
    endfunction

    // Checks one full frame (R2, R3, R4, R5, R10) and integration lengths (R6).
    task automatic check_frame(input string tag, input int trig_at, input int drop_at);
        int bad = 0, base_n = 0, sig_n = 0;
        logic [7:0] got, exp, bad_got, bad_exp;
        int bad_c = 0;
        for (int c = 0; c < FRAME; c++) begin
            @(negedge clk);
            got = observed();
            exp = expect_at(c);
            if (got !== exp && bad == 0) begin
                bad_got = got; bad_exp = exp; bad_c = c;
            end
            if (got !== exp) bad++;
            if (got[0] && got[1]) base_n++;
            if (got[0] && got[2]) sig_n++;
            trig = (c == trig_at);
            if (c == drop_at) run = 1'b0;
        end
        trig = 1'b0;
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R2/R10 %s: cycle %0d got %b expected %b", tag, bad_c, bad_got, bad_exp);
        end
        checks++;
        if (base_n != SUB - 1 || sig_n != SUB - 1) begin
            errors++;
            $display("FAIL R6 %s: base %0d signal %0d expected %0d", tag, base_n, sig_n, SUB - 1);
        end
    endtask

    task automatic check_idle(input string tag, input int n);
        int bad = 0;
        logic [7:0] got = '0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (observed() != 8'h00) begin
                bad++;
                got = observed();
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: got %b expected 00000000", tag, got);
        end
    endtask

    task automatic test_reset();
        checks++;
        if (observed() !== 8'h00) begin
            errors++;
            $display("FAIL R1 in reset: got %b expected 00000000", observed());
        end
        @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1 after reset", 8);
    endtask

    task automatic test_burst3();
        run = 1'b1; cont_mode = 1'b0; n_frames = 8'd3; trig = 1'b1;
        check_frame("R7 burst frame 1", -1, -1);
        check_frame("R7 burst frame 2", -1, -1);
        check_frame("R7 burst frame 3", -1, -1);
        check_idle("R7 idle after 3 frames", FRAME + 5);
    endtask

    task automatic test_retrigger();
        n_frames = 8'd2; trig = 1'b1;
        check_frame("R7 retrig frame 1", 15, -1);
        check_frame("R7 retrig frame 2", 3, -1);
        check_idle("R7 retrigger ignored", FRAME + 5);
    endtask

    task automatic test_zero_count();
        n_frames = 8'd0; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check_idle("R7 zero frame count", 2 * FRAME);
    endtask

    task automatic test_single();
        n_frames = 8'd1; trig = 1'b1;
        check_frame("R7 single frame", -1, -1);
        check_idle("R7 idle after single", FRAME);
    endtask

    task automatic test_continuous();
        run = 1'b1; cont_mode = 1'b1;
        for (int f = 0; f < 4; f++) check_frame("R8 continuous", -1, -1);
        check_frame("R9 frame with run drop", -1, 2 * SUB + 3);
        check_idle("R9 parked after run drop", FRAME + 5);
        cont_mode = 1'b0;
    endtask

    task automatic test_run_low();
        run = 1'b0; n_frames = 8'd2;
        for (int k = 0; k < 3; k++) begin
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            @(negedge clk);
        end
        check_idle("R9 trigger while run low", 2 * FRAME);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_burst3();
        test_retrigger();
        test_zero_count();
        test_single();
        test_continuous();
        test_run_low();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule